// File: doc/BRIEF.md
# Quadrature Position Decoder with Index

This block turns the two phase signals of an incremental encoder into a signed position count. The phase and index inputs must already be synchronized to the block clock. A small state machine remembers the last phase pair. It classifies each new pair as a forward step, a reverse step, no change, or an illegal jump. A resolution gate then passes on one, two or four counts per encoder cycle. The position register adds or subtracts one for each count it receives. It wraps at both ends of its range and pulses an event output when it wraps.

A rising edge on the index input marks the absolute reference. It forces the count to the midpoint of the range and pulses an index event. The tracker has four states, named after the phase pair {A,B}: PH_00, PH_10, PH_11 and PH_01. Each state checks the new pair against itself. A change to the next state in the ring PH_00→PH_10→PH_11→PH_01→PH_00 is the transition MV_FWD. A change to the previous state is MV_REV. The same pair is MV_HOLD. A change to the opposite pair is MV_BAD. In every case the next state is the pair just seen.

Top module: `qdec_core`

## Requirements
- R1: After reset `position` is the midpoint 2^(W-1) (0x8000 for W=16), `dir_up` is 1, and `index_evt`, `overflow_evt`, `underflow_evt` and `illegal_err` are 0. The tracker starts in PH_00, so the phases must be low during reset.
- R2: With `res_sel`=0 (x1), only a rising edge of phase A counts. It counts up when B is low and down when B is high. Edges of B and falling edges of A leave `position` unchanged.
- R3: With `res_sel`=1 (x2), both edges of A count. A rising edge counts up when B is low and down when B is high. A falling edge counts up when B is high and down when B is low. Edges of B leave `position` unchanged.
- R4: With `res_sel`=2 or 3 (x4), every single-phase change counts. The order {A,B} 00→10→11→01→00 counts up, and the reverse order counts down.
- R5: If both phases change in the same clock, `position` is unchanged and `illegal_err` becomes 1. It stays 1 until reset. The tracker takes on the new pair, so later steps are decoded from there.
- R6: A rising edge of `index_in` sets `position` to the midpoint. `index_evt` is high for exactly that one cycle. The index wins over a phase step in the same clock. Holding `index_in` high raises no further events.
- R7: An up count from the all-ones value gives 0, and `overflow_evt` is high for that one cycle only.
- R8: A down count from 0 gives the all-ones value, and `underflow_evt` is high for that one cycle only.
- R9: `dir_up` is 1 after an up count and 0 after a down count. It keeps its value when no count happens.
- R10: Every result appears at the first rising clock edge after the inputs that cause it, with no further delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| phase_a | input | 1 | Encoder phase A, synchronized |
| phase_b | input | 1 | Encoder phase B, synchronized |
| index_in | input | 1 | Encoder reference marker, synchronized |
| res_sel | input | 2 | Resolution select: 0 x1, 1 x2, 2 or 3 x4 |
| position | output | W | Position count, wrapping |
| dir_up | output | 1 | Direction of the last counted step |
| index_evt | output | 1 | One-cycle pulse when the index reloads the count |
| overflow_evt | output | 1 | One-cycle pulse on wrap from all-ones to zero |
| underflow_evt | output | 1 | One-cycle pulse on wrap from zero to all-ones |
| illegal_err | output | 1 | Sticky flag for a double phase change |

## Verification
Each output is a register loaded at the first rising edge after the input change that causes it: the count, the direction, all three pulses and the sticky error. So every result is due exactly one edge after its stimulus. The bench drives all inputs on the falling edge and samples at the following falling edge, half a period after the edge that updates the outputs. To check that a pulse lasts one cycle, the bench samples once more at the falling edge after that, while the causing input is held. In this way a late or stretched pulse is reported as a FAIL.

// File: rtl/qdec_pkg.sv
package qdec_pkg;
    // Resolution codes carried on res_sel
    typedef enum logic [1:0] {
        RES_X1  = 2'd0,
        RES_X2  = 2'd1,
        RES_X4  = 2'd2,
        RES_X4A = 2'd3
    } res_e;

    // Phase pair states, encoded {A,B}
    typedef enum logic [1:0] {
        PH_00 = 2'b00,
        PH_01 = 2'b01,
        PH_10 = 2'b10,
        PH_11 = 2'b11
    } phase_e;

    // Classified movement between consecutive pairs
    typedef enum logic [1:0] {
        MV_HOLD = 2'd0,
        MV_FWD  = 2'd1,
        MV_REV  = 2'd2,
        MV_BAD  = 2'd3
    } move_e;
endpackage

// File: rtl/qdec_phase_fsm.sv
module qdec_phase_fsm
    import qdec_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] pair_in,
    output move_e      move,
    output logic       a_prev
);
    phase_e st_q;
    phase_e st_d;

    assign st_d = phase_e'(pair_in);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= PH_00;
        else        st_q <= st_d;
    end

    // Output decode: classify the transition from st_q to the new pair
    always_comb begin
        move = MV_HOLD;
        unique case (st_q)
            PH_00: begin
                if      (st_d == PH_10) move = MV_FWD;
                else if (st_d == PH_01) move = MV_REV;
                else if (st_d == PH_11) move = MV_BAD;
            end
            PH_10: begin
                if      (st_d == PH_11) move = MV_FWD;
                else if (st_d == PH_00) move = MV_REV;
                else if (st_d == PH_01) move = MV_BAD;
            end
            PH_11: begin
                if      (st_d == PH_01) move = MV_FWD;
                else if (st_d == PH_10) move = MV_REV;
                else if (st_d == PH_00) move = MV_BAD;
            end
            PH_01: begin
                if      (st_d == PH_00) move = MV_FWD;
                else if (st_d == PH_11) move = MV_REV;
                else if (st_d == PH_10) move = MV_BAD;
            end
            default: move = MV_HOLD;
        endcase
    end

    assign a_prev = st_q[1];

    AST_BAD_BOTH_CHANGED: assert property (@(posedge clk) disable iff (!rst_n)
        (move == MV_BAD) |-> (st_d[1] != st_q[1]) && (st_d[0] != st_q[0])); // R5
endmodule

// File: rtl/qdec_res_gate.sv
module qdec_res_gate
    import qdec_pkg::*;
(
    input  logic [1:0] res_sel,
    input  move_e      move,
    input  logic       a_prev,
    input  logic       a_now,
    output logic       step_up,
    output logic       step_dn,
    output logic       illegal
);
    res_e res;
    logic qualify;
    logic legal;

    assign res   = res_e'(res_sel);
    assign legal = (move == MV_FWD) || (move == MV_REV);

    always_comb begin
        qualify = 1'b0;
        unique case (res)
            RES_X1:  qualify = a_now && !a_prev;
            RES_X2:  qualify = a_now != a_prev;
            RES_X4,
            RES_X4A: qualify = 1'b1;
            default: qualify = 1'b0;
        endcase
    end

    assign step_up = legal && qualify && (move == MV_FWD);
    assign step_dn = legal && qualify && (move == MV_REV);
    assign illegal = (move == MV_BAD);
endmodule

// File: rtl/qdec_pos_counter.sv
module qdec_pos_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step_up,
    input  logic         step_dn,
    input  logic         illegal,
    input  logic         idx_hit,
    output logic [W-1:0] position,
    output logic         dir_up,
    output logic         index_evt,
    output logic         overflow_evt,
    output logic         underflow_evt,
    output logic         illegal_err
);
    localparam logic [W-1:0] MID = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] TOP = {W{1'b1}};
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            position      <= MID;
            dir_up        <= 1'b1;
            index_evt     <= 1'b0;
            overflow_evt  <= 1'b0;
            underflow_evt <= 1'b0;
            illegal_err   <= 1'b0;
        end else begin
            overflow_evt  <= 1'b0;
            underflow_evt <= 1'b0;
            index_evt     <= idx_hit;
            illegal_err   <= illegal_err || illegal;
            if (idx_hit) begin
                position <= MID;
            end else if (step_up) begin
                position     <= position + ONE;
                overflow_evt <= (position == TOP);
                dir_up       <= 1'b1;
            end else if (step_dn) begin
                position      <= position - ONE;
                underflow_evt <= (position == '0);
                dir_up        <= 1'b0;
            end
        end
    end

    AST_STEP_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        !index_evt |-> (position == $past(position) || position == W'($past(position) + ONE)
                        || position == W'($past(position) - ONE))); // R4
    AST_OVF_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_evt |-> (position == '0) && ($past(position) == TOP)); // R7
    AST_UNF_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        underflow_evt |-> (position == TOP) && ($past(position) == '0)); // R8
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_err |=> illegal_err); // R5
    AST_WRAP_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(overflow_evt && underflow_evt)); // R7
endmodule

// File: rtl/qdec_core.sv
module qdec_core
    import qdec_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         phase_a,
    input  logic         phase_b,
    input  logic         index_in,
    input  logic [1:0]   res_sel,
    output logic [W-1:0] position,
    output logic         dir_up,
    output logic         index_evt,
    output logic         overflow_evt,
    output logic         underflow_evt,
    output logic         illegal_err
);
    localparam logic [W-1:0] MID = {1'b1, {(W-1){1'b0}}};

    move_e move;
    logic  a_prev;
    logic  step_up;
    logic  step_dn;
    logic  illegal;
    logic  idx_q;
    logic  idx_hit;

    always_ff @(posedge clk) begin
        if (!rst_n) idx_q <= 1'b0;
        else        idx_q <= index_in;
    end
    assign idx_hit = index_in && !idx_q;

    qdec_phase_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .pair_in ({phase_a, phase_b}),
        .move    (move),
        .a_prev  (a_prev)
    );

    qdec_res_gate u_gate (
        .res_sel (res_sel),
        .move    (move),
        .a_prev  (a_prev),
        .a_now   (phase_a),
        .step_up (step_up),
        .step_dn (step_dn),
        .illegal (illegal)
    );

    qdec_pos_counter #(.W(W)) u_cnt (
        .clk           (clk),
        .rst_n         (rst_n),
        .step_up       (step_up),
        .step_dn       (step_dn),
        .illegal       (illegal),
        .idx_hit       (idx_hit),
        .position      (position),
        .dir_up        (dir_up),
        .index_evt     (index_evt),
        .overflow_evt  (overflow_evt),
        .underflow_evt (underflow_evt),
        .illegal_err   (illegal_err)
    );

    AST_IDX_MID: assert property (@(posedge clk) disable iff (!rst_n)
        (index_in && !idx_q) |=> (position == MID) && index_evt); // R6
    AST_ILLEGAL_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> !step_up && !step_dn); // R5
    AST_ONE_DIRECTION: assert property (@(posedge clk) disable iff (!rst_n)
        !(step_up && step_dn)); // R4
    AST_X1_ONLY_A_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (res_sel == 2'd0 && (step_up || step_dn)) |-> phase_a && !a_prev); // R2
endmodule

// File: tb/qdec_core_tb_top.sv
module qdec_core_tb_top;
    localparam int W = 16;
    localparam logic [15:0] MID = 16'h8000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic phase_a = 1'b0;
    logic phase_b = 1'b0;
    logic index_in = 1'b0;
    logic [1:0] res_sel = 2'd0;
    logic [W-1:0] position;
    logic dir_up, index_evt, overflow_evt, underflow_evt, illegal_err;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    qdec_core #(.W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .phase_a(phase_a), .phase_b(phase_b),
        .index_in(index_in), .res_sel(res_sel), .position(position),
        .dir_up(dir_up), .index_evt(index_evt), .overflow_evt(overflow_evt),
        .underflow_evt(underflow_evt), .illegal_err(illegal_err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Drive a pair on the falling edge, then sample at the next falling edge
    task automatic drive(input logic [1:0] ab);
        phase_a = ab[1];
        phase_b = ab[0];
        @(negedge clk);
    endtask

    function automatic logic [1:0] fwd(input logic [1:0] p);
        case (p)
            2'b00: return 2'b10;
            2'b10: return 2'b11;
            2'b11: return 2'b01;
            default: return 2'b00;
        endcase
    endfunction

    function automatic logic [1:0] rev(input logic [1:0] p);
        case (p)
            2'b00: return 2'b01;
            2'b01: return 2'b11;
            2'b11: return 2'b10;
            default: return 2'b00;
        endcase
    endfunction

    task automatic t_reset();
        chk("R1 position", 32'(position), 32'(MID));
        chk("R1 dir_up", 32'(dir_up), 1);
        chk("R1 flags", {28'd0, index_evt, overflow_evt, underflow_evt, illegal_err}, 0);
    endtask

    task automatic t_x1();
        res_sel = 2'd0;
        drive(2'b10); chk("R2 A rise B low", 32'(position), 32'h8001);
        chk("R10 R9 dir up", 32'(dir_up), 1);
        drive(2'b11); chk("R2 B rise ignored", 32'(position), 32'h8001);
        drive(2'b01); chk("R2 A fall ignored", 32'(position), 32'h8001);
        drive(2'b11); chk("R2 A rise B high", 32'(position), 32'h8000);
        chk("R9 dir down", 32'(dir_up), 0);
        drive(2'b11); chk("R9 dir held", 32'(dir_up), 0);
    endtask

    task automatic t_x2();
        res_sel = 2'd1;
        drive(2'b01); chk("R3 A fall B high", 32'(position), 32'h8001);
        drive(2'b00); chk("R3 B fall ignored", 32'(position), 32'h8001);
        drive(2'b10); chk("R3 A rise B low", 32'(position), 32'h8002);
        drive(2'b00); chk("R3 A fall B low", 32'(position), 32'h8001);
        chk("R3 dir", 32'(dir_up), 0);
    endtask

    task automatic t_x4();
        logic [1:0] p = 2'b00;
        res_sel = 2'd2;
        for (int i = 0; i < 4; i++) begin p = fwd(p); drive(p); end
        chk("R4 four fwd", 32'(position), 32'h8005);
        chk("R4 dir up", 32'(dir_up), 1);
        res_sel = 2'd3;
        for (int i = 0; i < 4; i++) begin p = rev(p); drive(p); end
        chk("R4 four rev code3", 32'(position), 32'h8001);
        chk("R4 dir down", 32'(dir_up), 0);
    endtask

    task automatic t_illegal();
        res_sel = 2'd2;
        chk("R5 err clear before", 32'(illegal_err), 0);
        drive(2'b11); chk("R5 no count", 32'(position), 32'h8001);
        chk("R5 err set", 32'(illegal_err), 1);
        drive(2'b01); chk("R5 resync fwd", 32'(position), 32'h8002);
        drive(2'b00); chk("R5 err sticky", 32'(illegal_err), 1);
        chk("R5 second step", 32'(position), 32'h8003);
    endtask

    task automatic t_index();
        index_in = 1'b1;
        @(negedge clk);
        chk("R6 reload", 32'(position), 32'(MID));
        chk("R6 pulse", 32'(index_evt), 1);
        drive(2'b10);
        chk("R6 pulse one cycle", 32'(index_evt), 0);
        chk("R6 held no reload", 32'(position), 32'h8001);
        index_in = 1'b0;
        drive(2'b10);
        index_in = 1'b1;
        drive(2'b11);
        chk("R6 index beats step", 32'(position), 32'(MID));
        index_in = 1'b0;
        drive(2'b01); drive(2'b00);
        chk("R6 after index", 32'(position), 32'h8002);
    endtask

    task automatic t_wrap();
        logic [1:0] p = 2'b00;
        index_in = 1'b1; @(negedge clk); index_in = 1'b0; @(negedge clk);
        for (int i = 0; i < 32767; i++) begin p = fwd(p); drive(p); end
        chk("R7 at top", 32'(position), 32'hFFFF);
        chk("R7 no early ovf", 32'(overflow_evt), 0);
        p = fwd(p); drive(p);
        chk("R7 wrap to zero", 32'(position), 0);
        chk("R7 ovf pulse", 32'(overflow_evt), 1);
        @(negedge clk);
        chk("R7 ovf one cycle", 32'(overflow_evt), 0);
        p = rev(p); drive(p);
        chk("R8 wrap to top", 32'(position), 32'hFFFF);
        chk("R8 unf pulse", 32'(underflow_evt), 1);
        @(negedge clk);
        chk("R8 unf one cycle", 32'(underflow_evt), 0);
        phase_a = 1'b0; phase_b = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_x1();
        t_x2();
        t_x4();
        t_illegal();
        t_index();
        t_wrap();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule